// File: doc/BRIEF.md
# Frequency-Domain Channel Response Multiplier

This block is the datapath core of a frequency-domain channel emulator. Each transform bin comes from the forward transform of one transmit antenna's signal. The block multiplies that bin by a complex channel frequency response, which it looks up in a per-path memory by bin index. It adds the products of all transmit paths that feed one receive antenna. It then cuts the sum down to the width the inverse transform accepts.

Two small format stages sit at the converter edges. The first widens converter samples by two zero LSBs before the forward transform. The second narrows the real inverse-transform output to converter width. A host loads the response memories through a write port. That port takes effect only while a frame-boundary flag marks the gap between frames.

Top module: `chanresp_mac`

## Requirements
- R1: `adc_pad_out` equals `adc_in` with two zero bits appended below the LSB, which is the signed value times 4. It appears one clock edge after `adc_in` is sampled.
- R2: For each path p, a bin is multiplied by the response word stored for path p at address `bin_idx`. Different indices select different stored responses.
- R3: Each path's product is the full-precision complex product. The real part is ar*hr - ai*hi and the imaginary part is ar*hi + ai*hr, with bins of 26 bits and responses of 16 bits per component, all signed.
- R4: The products of all transmit paths are added without loss of precision before truncation. With two paths the sum is 44 bits wide.
- R5: `sum_re` and `sum_im` keep the 24 most significant bits of the 44-bit sum. This is floor(sum / 2^20), with no rounding.
- R6: When `host_we` and `frame_idle` are both high, the response {`host_re`,`host_im`} is written for path `host_path` at address `host_addr`.
- R7: When `frame_idle` is low, `host_we` has no effect on any stored response.
- R8: Each accepted bin produces exactly one `sum_valid` pulse, four clock edges after the bin is sampled. `sum_idx` carries the bin's index, and results leave in input order.
- R9: `dac_out` equals bits [33:20] of `ift_re_in`, which is floor(value / 2^20). It appears one clock edge later.
- R10: While `rst` is high, `sum_valid`, `adc_pad_out` and `dac_out` are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_in | input | 14 | Signed converter sample |
| adc_pad_out | output | 16 | Sample widened for the forward transform |
| bin_valid | input | 1 | Bin inputs carry a bin this cycle |
| bin_idx | input | 9 | Bin index, 0 to 511 |
| bin_re | input | 52 | Real bin parts, path p in bits [26p+25:26p] |
| bin_im | input | 52 | Imaginary bin parts, same packing |
| frame_idle | input | 1 | High between frames; enables host writes |
| host_we | input | 1 | Host write request |
| host_path | input | 1 | Path selected for the write |
| host_addr | input | 9 | Bin index written |
| host_re | input | 16 | Response real part |
| host_im | input | 16 | Response imaginary part |
| sum_valid | output | 1 | Result valid |
| sum_idx | output | 9 | Bin index of the result |
| sum_re | output | 24 | Truncated real sum |
| sum_im | output | 24 | Truncated imaginary sum |
| ift_re_in | input | 34 | Real inverse-transform output |
| dac_out | output | 14 | Sample narrowed for the converter |

## Verification
The assertions assume that bins arrive only inside a frame, so `bin_valid` and `frame_idle` are never high together. Under that assumption a host write can never hit an address that is being read. The bench loads all responses while `frame_idle` is high, lowers the flag before it streams any bin, and makes its one stray write attempt with the flag low. Bins arrive both back to back and with gaps, so the fixed four-edge latency and the in-order index tag are exercised under both spacings.

// File: rtl/chanresp_pkg.sv
package chanresp_pkg;
  localparam int CR_NTX    = 2;
  localparam int CR_NPTS   = 512;
  localparam int CR_ADC_W  = 14;
  localparam int CR_PAD_B  = 2;
  localparam int CR_BIN_W  = 26;
  localparam int CR_COEF_W = 16;
  localparam int CR_OUT_W  = 24;
  localparam int CR_IFT_W  = 34;
  localparam int CR_DAC_W  = 14;
endpackage

// File: rtl/chanresp_mem.sv
module chanresp_mem #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/chanresp_cmul.sv
module chanresp_cmul #(
  parameter int A_W  = 26,
  parameter int H_W  = 16,
  localparam int P_W = A_W + H_W,
  localparam int O_W = P_W + 1
) (
  input  logic                  clk,
  input  logic signed [A_W-1:0] a_re,
  input  logic signed [A_W-1:0] a_im,
  input  logic signed [H_W-1:0] h_re,
  input  logic signed [H_W-1:0] h_im,
  output logic signed [O_W-1:0] y_re,
  output logic signed [O_W-1:0] y_im
);
  logic signed [P_W-1:0] p_rr, p_ii, p_ri, p_ir;

  // stage 1: four partial products
  always_ff @(posedge clk) begin
    p_rr <= a_re * h_re;
    p_ii <= a_im * h_im;
    p_ri <= a_re * h_im;
    p_ir <= a_im * h_re;
  end

  // stage 2: combine with one growth bit
  always_ff @(posedge clk) begin
    y_re <= {p_rr[P_W-1], p_rr} - {p_ii[P_W-1], p_ii};
    y_im <= {p_ri[P_W-1], p_ri} + {p_ir[P_W-1], p_ir};
  end
endmodule

// File: rtl/chanresp_io_fmt.sv
module chanresp_io_fmt #(
  parameter int ADC_W = 14,
  parameter int PAD_B = 2,
  parameter int IFT_W = 34,
  parameter int DAC_W = 14,
  localparam int PAD_W = ADC_W + PAD_B,
  localparam int SH    = IFT_W - DAC_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [ADC_W-1:0] adc_in,
  output logic signed [PAD_W-1:0] adc_pad_out,
  input  logic signed [IFT_W-1:0] ift_in,
  output logic signed [DAC_W-1:0] dac_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      adc_pad_out <= '0;
      dac_out     <= '0;
    end else begin
      adc_pad_out <= {adc_in, {PAD_B{1'b0}}};
      dac_out     <= DAC_W'(ift_in >>> SH);
    end
  end
endmodule

// File: rtl/chanresp_mac.sv
module chanresp_mac
  import chanresp_pkg::*;
#(
  parameter int N_TX   = CR_NTX,
  parameter int NPTS   = CR_NPTS,
  parameter int ADC_W  = CR_ADC_W,
  parameter int PAD_B  = CR_PAD_B,
  parameter int BIN_W  = CR_BIN_W,
  parameter int COEF_W = CR_COEF_W,
  parameter int OUT_W  = CR_OUT_W,
  parameter int IFT_W  = CR_IFT_W,
  parameter int DAC_W  = CR_DAC_W,
  localparam int AW    = $clog2(NPTS),
  localparam int PSEL_W = (N_TX > 1) ? $clog2(N_TX) : 1,
  localparam int CM_W  = BIN_W + COEF_W + 1,
  localparam int SUM_W = CM_W + $clog2(N_TX),
  localparam int SH    = SUM_W - OUT_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic signed [ADC_W-1:0]    adc_in,
  output logic signed [ADC_W+PAD_B-1:0] adc_pad_out,
  input  logic                       bin_valid,
  input  logic [AW-1:0]              bin_idx,
  input  logic [N_TX*BIN_W-1:0]      bin_re,
  input  logic [N_TX*BIN_W-1:0]      bin_im,
  input  logic                       frame_idle,
  input  logic                       host_we,
  input  logic [PSEL_W-1:0]          host_path,
  input  logic [AW-1:0]              host_addr,
  input  logic signed [COEF_W-1:0]   host_re,
  input  logic signed [COEF_W-1:0]   host_im,
  output logic                       sum_valid,
  output logic [AW-1:0]              sum_idx,
  output logic signed [OUT_W-1:0]    sum_re,
  output logic signed [OUT_W-1:0]    sum_im,
  input  logic signed [IFT_W-1:0]    ift_re_in,
  output logic signed [DAC_W-1:0]    dac_out
);
  logic [2:0]    vld_pipe;
  logic [AW-1:0] idx_pipe [3];
  logic [N_TX*BIN_W-1:0] bre_d, bim_d;
  logic signed [CM_W-1:0] cm_re [N_TX];
  logic signed [CM_W-1:0] cm_im [N_TX];
  logic signed [SUM_W-1:0] acc_re, acc_im;

  chanresp_io_fmt #(.ADC_W(ADC_W), .PAD_B(PAD_B), .IFT_W(IFT_W), .DAC_W(DAC_W)) fmt_i (
    .clk(clk), .rst(rst), .adc_in(adc_in), .adc_pad_out(adc_pad_out),
    .ift_in(ift_re_in), .dac_out(dac_out)
  );

  // bins wait one edge for the synchronous response read
  always_ff @(posedge clk) begin
    bre_d <= bin_re;
    bim_d <= bin_im;
  end

  for (genvar p = 0; p < N_TX; p++) begin : g_path
    logic [2*COEF_W-1:0] rd;
    logic wr_en;
    assign wr_en = host_we && frame_idle && (host_path == PSEL_W'(p));

    chanresp_mem #(.DEPTH(NPTS), .DATA_W(2*COEF_W)) mem_i (
      .clk(clk), .we(wr_en), .waddr(host_addr), .wdata({host_re, host_im}),
      .raddr(bin_idx), .rdata(rd)
    );

    chanresp_cmul #(.A_W(BIN_W), .H_W(COEF_W)) mul_i (
      .clk(clk),
      .a_re(bre_d[p*BIN_W +: BIN_W]), .a_im(bim_d[p*BIN_W +: BIN_W]),
      .h_re(rd[2*COEF_W-1 -: COEF_W]), .h_im(rd[COEF_W-1:0]),
      .y_re(cm_re[p]), .y_im(cm_im[p])
    );
  end

  always_comb begin
    acc_re = '0;
    acc_im = '0;
    for (int p = 0; p < N_TX; p++) begin
      acc_re = acc_re + SUM_W'(cm_re[p]);
      acc_im = acc_im + SUM_W'(cm_im[p]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_pipe  <= '0;
      sum_valid <= 1'b0;
    end else begin
      vld_pipe  <= {vld_pipe[1:0], bin_valid};
      sum_valid <= vld_pipe[2];
    end
    idx_pipe[0] <= bin_idx;
    idx_pipe[1] <= idx_pipe[0];
    idx_pipe[2] <= idx_pipe[1];
    sum_idx     <= idx_pipe[2];
    sum_re      <= OUT_W'(acc_re >>> SH);
    sum_im      <= OUT_W'(acc_im >>> SH);
  end
endmodule

// File: rtl/chanresp_chk.sv
module chanresp_chk #(
  parameter int AW    = 9,
  parameter int ADC_W = 14,
  parameter int PAD_B = 2,
  parameter int IFT_W = 34,
  parameter int DAC_W = 14
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    bin_valid,
  input logic [AW-1:0]           bin_idx,
  input logic                    frame_idle,
  input logic                    sum_valid,
  input logic [AW-1:0]           sum_idx,
  input logic [ADC_W-1:0]        adc_in,
  input logic [ADC_W+PAD_B-1:0]  adc_pad_out,
  input logic [IFT_W-1:0]        ift_re_in,
  input logic [DAC_W-1:0]        dac_out
);
  assert_valid_latency_R8: assert property (@(posedge clk) disable iff (rst)
    bin_valid |-> ##4 sum_valid);

  assert_index_carried_R8: assert property (@(posedge clk) disable iff (rst)
    sum_valid |-> sum_idx == $past(bin_idx, 4));

  assert_pad_widen_R1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> adc_pad_out == {$past(adc_in), {PAD_B{1'b0}}});

  assert_dac_narrow_R9: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> dac_out == $past(ift_re_in[IFT_W-1 -: DAC_W]));

  assert_bins_in_frame_R7: assert property (@(posedge clk) disable iff (rst)
    bin_valid |-> !frame_idle);

  assert_reset_quiet_R10: assert property (@(posedge clk)
    $past(rst) |-> !sum_valid);
endmodule

bind chanresp_mac chanresp_chk #(
  .AW(AW), .ADC_W(ADC_W), .PAD_B(PAD_B), .IFT_W(IFT_W), .DAC_W(DAC_W)
) chk_i (
  .clk(clk), .rst(rst), .bin_valid(bin_valid), .bin_idx(bin_idx),
  .frame_idle(frame_idle), .sum_valid(sum_valid), .sum_idx(sum_idx),
  .adc_in(adc_in), .adc_pad_out(adc_pad_out), .ift_re_in(ift_re_in),
  .dac_out(dac_out)
);

// File: tb/chanresp_mac_tb_top.sv
`timescale 1ns/1ps
module chanresp_mac_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic signed [13:0] adc_in = '0;
  logic signed [15:0] adc_pad_out;
  logic bin_valid = 1'b0;
  logic [8:0] bin_idx = '0;
  logic [51:0] bin_re = '0, bin_im = '0;
  logic frame_idle = 1'b1;
  logic host_we = 1'b0;
  logic [0:0] host_path = '0;
  logic [8:0] host_addr = '0;
  logic signed [15:0] host_re = '0, host_im = '0;
  logic sum_valid;
  logic [8:0] sum_idx;
  logic signed [23:0] sum_re, sum_im;
  logic signed [33:0] ift_re_in = '0;
  logic signed [13:0] dac_out;

  chanresp_mac dut_i (
    .clk(clk), .rst(rst), .adc_in(adc_in), .adc_pad_out(adc_pad_out),
    .bin_valid(bin_valid), .bin_idx(bin_idx), .bin_re(bin_re), .bin_im(bin_im),
    .frame_idle(frame_idle), .host_we(host_we), .host_path(host_path),
    .host_addr(host_addr), .host_re(host_re), .host_im(host_im),
    .sum_valid(sum_valid), .sum_idx(sum_idx), .sum_re(sum_re), .sum_im(sum_im),
    .ift_re_in(ift_re_in), .dac_out(dac_out)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  typedef struct { int idx; longint re; longint im; } exp_t;
  exp_t sb [$];
  longint mre [2][512];
  longint mim [2][512];

  task automatic check(input bit ok, input string req, input longint got, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic host_wr(input int p, input int a, input int re, input int im);
    @(negedge clk);
    host_we = 1'b1; host_path = p[0:0]; host_addr = a[8:0];
    host_re = re[15:0]; host_im = im[15:0];
    if (frame_idle) begin mre[p][a] = re; mim[p][a] = im; end
    @(negedge clk);
    host_we = 1'b0;
  endtask

  // drives one bin for one cycle and pushes its expected result
  task automatic send_bin(input int a, input longint r0, input longint i0,
                          input longint r1, input longint i1);
    exp_t e;
    longint fr, fi;
    @(negedge clk);
    bin_valid = 1'b1; bin_idx = a[8:0];
    bin_re = {r1[25:0], r0[25:0]};
    bin_im = {i1[25:0], i0[25:0]};
    // R3/R4: full-precision complex product summed over both paths
    fr = r0*mre[0][a] - i0*mim[0][a] + r1*mre[1][a] - i1*mim[1][a];
    fi = r0*mim[0][a] + i0*mre[0][a] + r1*mim[1][a] + i1*mre[1][a];
    e.idx = a; e.re = fr >>> 20; e.im = fi >>> 20; // R5 floor truncation
    sb.push_back(e);
  endtask

  task automatic bins_off();
    @(negedge clk);
    bin_valid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && sum_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R8 unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(sum_idx == e.idx[8:0], "R8 index", sum_idx, e.idx);
        check(longint'(sum_re) == e.re, "R5 real", longint'(sum_re), e.re);
        check(longint'(sum_im) == e.im, "R5 imag", longint'(sum_im), e.im);
      end
    end
  end

  initial begin
    #(5ns * 20000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got 1 expected 0");
      report();
    end
  end

  task automatic pad_check(input int v);
    @(negedge clk); adc_in = v[13:0];
    @(negedge clk);
    check(longint'(adc_pad_out) == longint'(v) * 4, "R1 pad", longint'(adc_pad_out), longint'(v) * 4);
  endtask

  task automatic dac_check(input longint v);
    longint ex;
    @(negedge clk); ift_re_in = v[33:0];
    ex = longint'(ift_re_in) >>> 20;
    @(negedge clk);
    check(longint'(dac_out) == ex, "R9 dac", longint'(dac_out), ex);
  endtask

  initial begin
    adc_in = 14'sd77; ift_re_in = 34'sd123456789;
    repeat (3) @(negedge clk);
    check(sum_valid == 1'b0, "R10 valid", sum_valid, 0);
    check(adc_pad_out == 0, "R10 pad", adc_pad_out, 0);
    check(dac_out == 0, "R10 dac", dac_out, 0);
    rst = 1'b0;

    pad_check(-8192); pad_check(8191); pad_check(-1); pad_check(1234);
    dac_check(-(longint'(1) <<< 33)); dac_check((longint'(1) <<< 33) - 1);
    dac_check(-1); dac_check(1048575); dac_check(1048576);

    // R6: load responses between frames
    host_wr(0, 0, 16384, 0);      host_wr(1, 0, 0, 0);
    host_wr(0, 1, 1000, -2000);   host_wr(1, 1, -3000, 4000);
    host_wr(0, 5, 32767, -32768); host_wr(1, 5, -32768, 32767);
    host_wr(0, 511, -7, 12345);   host_wr(1, 511, 555, 1);
    host_wr(0, 200, 100, 100);    host_wr(1, 200, 100, 100);

    frame_idle = 1'b0;
    // R7: write attempt during a frame must leave entry 200 unchanged
    host_wr(0, 200, -5000, 9000);

    // R2/R3/R4/R5/R8: back-to-back bins
    send_bin(0, 1000, -1000, 55, 66);
    send_bin(1, 123456, -654321, -33554432, 33554431);
    send_bin(5, 33554431, -33554432, 33554431, -33554432);
    send_bin(511, -1, 1, 7, -7);
    send_bin(200, 2097152, -2097152, 1048576, 3);
    bins_off();
    repeat (3) @(negedge clk);
    // gapped bins
    send_bin(5, -20000000, 15000000, 9, -9); bins_off();
    send_bin(0, 4096, 0, 0, 0);              bins_off();
    @(negedge clk);
    send_bin(200, -1048576, 1048575, 0, 0);  bins_off();
    repeat (8) @(negedge clk);
    check(sb.size() == 0, "R8 missing results", sb.size(), 0);
    done = 1;
    report();
  end
endmodule